// File: doc/BRIEF.md
# Data-Strobe Transmit Serializer

This block sits between a link-layer controller and the external line transceivers of a single-port backplane node. Once per system clock tick it latches a pair of data bits from the link. At twice the tick rate it sends those bits one after the other as a single serial stream. The stream uses data-strobe encoding: the data line carries each bit as it is. The strobe line toggles whenever the new bit equals the bit before it, so that exactly one of the two lines changes in every bit period.

The block runs from the fast reference clock. A bit-rate enable derived from that clock gives two bit periods per system tick. A two-bit speed select chooses the rate. At full rate one bit leaves per reference clock, and the system tick is the reference divided by two. At half rate one bit leaves every second reference clock. The two codes with the upper select bit set are reserved and hold the block silent. The link keeps `tx_act` high for the length of a packet and offers a new pair whenever `pair_take` is high. Two separate enable outputs control the external open-collector or tri-state drivers of the data and strobe lines. Between packets both enables are released and the encoder returns to its zero state.

Top module: `ds_tx_serializer`

## Requirements
- R1: After reset, `ds_data`, `ds_strb`, `data_drv_en` and `strb_drv_en` are all low.
- R2: `pair_take` is high for one cycle in every two bit periods: every 2 clocks at full rate and every 4 clocks at half rate. A pair (`tx_act`, `tx_pair`) is latched only on a clock edge where `pair_take` is high.
- R3: Of each latched pair, `tx_pair[0]` goes out first and `tx_pair[1]` goes out one bit period later. A packet of N pairs produces exactly 2N bits.
- R4: In every bit period, `ds_data` equals the bit being sent. `ds_strb` toggles exactly when that bit equals the previous bit, so `ds_data ^ ds_strb` changes once per bit period.
- R5: Each packet starts from data=0 and strobe=0. A first bit of 0 sets the strobe, and a first bit of 1 sets the data line with the strobe low.
- R6: `data_drv_en` and `strb_drv_en` are high together from the edge that sends the first bit until the packet ends. While they are low, `ds_data` and `ds_strb` are low.
- R7: Speed select `speed_sel` = {SEL1, SEL0}: 2'b00 is full rate, with one bit per clock. 2'b01 is half rate, with one bit per two clocks.
- R8: With `speed_sel[1]`=1 (codes 2'b10 and 2'b11, reserved), `pair_take` stays low. From the next clock edge on, both enables and both line outputs are low, even in the middle of a packet.
- R9: When `tx_act` is low at a `pair_take` edge, the packet ends at that edge: both enables and both line outputs are low after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; bit clock at full rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| speed_sel | input | 2 | {SEL1, SEL0}: 00 full rate, 01 half rate, 1x reserved |
| tx_act | input | 1 | Link transmit-active; sampled with each pair |
| tx_pair | input | 2 | Bit pair from the link; bit 0 is sent first |
| pair_take | output | 1 | System tick: a pair is latched at the coming edge |
| ds_data | output | 1 | Encoded data line |
| ds_strb | output | 1 | Encoded strobe line |
| data_drv_en | output | 1 | Enable for the data-line transceiver |
| strb_drv_en | output | 1 | Enable for the strobe-line transceiver |

## Verification
The assertions assume that `speed_sel` moves between the two valid rates only while the line is idle. A change into a reserved code may happen at any time. The rate-dependent properties therefore look only at edges that followed a cycle of full rate. The stimulus changes the rate only between packets, with idle cycles around each change. It forces a reserved code in the middle of a packet only in a directed test. The link side is driven as a well-behaved controller: it presents a new pair exactly when `pair_take` is high and drops `tx_act` only at such a tick.

// File: rtl/ds_tx_pkg.sv
package ds_tx_pkg;

    typedef enum logic [1:0] {
        SPD_FULL  = 2'b00,
        SPD_HALF  = 2'b01,
        SPD_RSV_A = 2'b10,
        SPD_RSV_B = 2'b11
    } speed_e;

    typedef struct packed {
        logic data;
        logic strb;
    } line_st_t;

    typedef struct packed {
        logic act;
        logic hold;
    } pair_st_t;

    function automatic logic is_reserved(input logic [1:0] sel);
        return sel[1];
    endfunction

endpackage

// File: rtl/ds_rate_gen.sv
module ds_rate_gen
    import ds_tx_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] speed_sel,
    output logic       bit_en,
    output logic       pair_take
);
    localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_DIV - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ph;
    } rate_st_t;

    rate_st_t st_d, st_q;
    logic     rsv;
    logic     half;

    always_comb begin
        st_d = st_q;
        rsv  = is_reserved(speed_sel);
        half = (speed_sel == SPD_HALF);
        bit_en    = !rsv && (!half || (st_q.cnt == CNT_LAST));
        pair_take = bit_en && !st_q.ph;
        if (rsv || !half) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == CNT_LAST) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        if (rsv) begin
            st_d.ph = 1'b0;
        end else if (bit_en) begin
            st_d.ph = !st_q.ph;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/ds_encoder.sv
module ds_encoder
    import ds_tx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic emit,
    input  logic bit_in,
    output logic data_o,
    output logic strb_o
);
    line_st_t ln_d, ln_q;

    always_comb begin
        ln_d = ln_q;
        if (clear) begin
            ln_d = '0;
        end else if (emit) begin
            ln_d.data = bit_in;
            if (bit_in == ln_q.data) begin
                ln_d.strb = !ln_q.strb;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ln_q <= '0;
        end else begin
            ln_q <= ln_d;
        end
    end

    assign data_o = ln_q.data;
    assign strb_o = ln_q.strb;

endmodule

// File: rtl/ds_tx_serializer.sv
module ds_tx_serializer
    import ds_tx_pkg::*;
#(
    parameter int HALF_DIV  = 2,
    parameter bit FIRST_LSB = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] speed_sel,
    input  logic       tx_act,
    input  logic [1:0] tx_pair,
    output logic       pair_take,
    output logic       ds_data,
    output logic       ds_strb,
    output logic       data_drv_en,
    output logic       strb_drv_en
);
    pair_st_t ps_d, ps_q;
    logic     bit_en;
    logic     first_bit;
    logic     second_bit;
    logic     enc_clear;
    logic     enc_emit;
    logic     enc_bit;
    logic     rsv;

    ds_rate_gen #(.HALF_DIV(HALF_DIV)) rate_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .speed_sel (speed_sel),
        .bit_en    (bit_en),
        .pair_take (pair_take)
    );

    generate
        if (FIRST_LSB) begin : g_lsb_first
            assign first_bit  = tx_pair[0];
            assign second_bit = tx_pair[1];
        end else begin : g_msb_first
            assign first_bit  = tx_pair[1];
            assign second_bit = tx_pair[0];
        end
    endgenerate

    always_comb begin
        ps_d      = ps_q;
        rsv       = is_reserved(speed_sel);
        enc_clear = rsv || (pair_take && !tx_act);
        enc_emit  = pair_take ? tx_act : (bit_en && ps_q.act);
        enc_bit   = pair_take ? first_bit : ps_q.hold;
        if (rsv) begin
            ps_d.act = 1'b0;
        end else if (pair_take) begin
            ps_d.act  = tx_act;
            ps_d.hold = second_bit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ps_q <= '0;
        end else begin
            ps_q <= ps_d;
        end
    end

    ds_encoder enc_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (enc_clear),
        .emit   (enc_emit),
        .bit_in (enc_bit),
        .data_o (ds_data),
        .strb_o (ds_strb)
    );

    assign data_drv_en = ps_q.act;
    assign strb_drv_en = ps_q.act;

endmodule

// File: rtl/ds_tx_checker.sv
module ds_tx_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] speed_sel,
    input logic       pair_take,
    input logic       ds_data,
    input logic       ds_strb,
    input logic       data_drv_en,
    input logic       strb_drv_en
);
    AST_RSV_DATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        speed_sel[1] |=> (!data_drv_en && !ds_data && !ds_strb)); // R8
    AST_RSV_STRB_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        speed_sel[1] |=> !strb_drv_en); // R8
    AST_IDLE_LINES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_drv_en && !strb_drv_en) |-> (!ds_data && !ds_strb)); // R6
    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pair_take |=> !pair_take); // R2
    AST_XOR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (data_drv_en && $past(speed_sel) == 2'b00)
        |-> ((ds_data ^ ds_strb) != $past(ds_data ^ ds_strb))); // R4
    AST_STRB_RULE: assert property (@(posedge clk) disable iff (!rst_n)
        (data_drv_en && $past(data_drv_en) && $past(speed_sel) == 2'b00
         && ds_data == $past(ds_data)) |-> (ds_strb != $past(ds_strb))); // R4
endmodule

bind ds_tx_serializer ds_tx_checker chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .speed_sel   (speed_sel),
    .pair_take   (pair_take),
    .ds_data     (ds_data),
    .ds_strb     (ds_strb),
    .data_drv_en (data_drv_en),
    .strb_drv_en (strb_drv_en)
);

// File: tb/ds_tx_serializer_tb_top.sv
module ds_tx_serializer_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] speed_sel = 2'b00;
    logic       tx_act = 1'b0;
    logic [1:0] tx_pair = 2'b00;
    logic       pair_take, ds_data, ds_strb, data_drv_en, strb_drv_en;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ds_tx_serializer dut_i (
        .clk (clk), .rst_n (rst_n), .speed_sel (speed_sel), .tx_act (tx_act),
        .tx_pair (tx_pair), .pair_take (pair_take), .ds_data (ds_data),
        .ds_strb (ds_strb), .data_drv_en (data_drv_en), .strb_drv_en (strb_drv_en)
    );

    // {speed, pair count, payload sent LSB first}
    localparam logic [12:0] VEC [6] = '{
        {2'b00, 3'd4, 8'hB4},
        {2'b00, 3'd1, 8'h00},
        {2'b00, 3'd4, 8'hFF},
        {2'b01, 3'd3, 8'h2C},
        {2'b01, 3'd4, 8'h00},
        {2'b00, 3'd4, 8'h55}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            tx_act = 1'b0;
        end
    endtask

    task automatic run_pkt(input logic [1:0] spd, input int np, input logic [7:0] pl);
        int  k = 0, nb = 0, last_bit = -1, last_tick = -1, period;
        bit  prev_x = 1'b0, prev_d = 1'b0, prev_s = 1'b0, took, ending = 1'b0;
        period = spd[0] ? 2 : 1;
        @(negedge clk);
        speed_sel = spd;
        tx_act = 1'b0;
        idle(4);
        for (int c = 0; c < 80; c++) begin
            @(negedge clk);
            took = pair_take;
            if (took) begin
                if (last_tick >= 0 && k > 0)
                    check(cyc - last_tick == 2 * period, "R2 tick spacing", cyc - last_tick, 2 * period);
                last_tick = cyc;
                if (k < np) begin
                    tx_act = 1'b1;
                    tx_pair = pl[2*k +: 2];
                    k++;
                end else begin
                    tx_act = 1'b0;
                    tx_pair = 2'b11;
                    ending = 1'b1;
                end
            end
            @(posedge clk);
            #1;
            if (data_drv_en && ((ds_data ^ ds_strb) != prev_x)) begin
                check(ds_data == pl[nb], "R3 bit order", ds_data, pl[nb]);
                if (nb == 0)
                    check(ds_strb == (pl[0] == 1'b0), "R5 first strobe", ds_strb, pl[0] == 1'b0);
                else if (ds_data == prev_d)
                    check(ds_strb != prev_s, "R4 strobe toggle", ds_strb, !prev_s);
                else
                    check(ds_strb == prev_s, "R4 strobe hold", ds_strb, prev_s);
                if (last_bit >= 0)
                    check(cyc - last_bit == period, "R7 bit period", cyc - last_bit, period);
                last_bit = cyc;
                nb++;
            end
            if (nb > 0 && !ending)
                check(data_drv_en && strb_drv_en, "R6 enables during packet",
                      {data_drv_en, strb_drv_en}, 3);
            prev_x = ds_data ^ ds_strb;
            prev_d = ds_data;
            prev_s = ds_strb;
            if (took && ending) begin
                check(!data_drv_en && !strb_drv_en && !ds_data && !ds_strb, "R9 packet end",
                      {data_drv_en, strb_drv_en, ds_data, ds_strb}, 0);
                break;
            end
        end
        check(nb == 2 * np, "R3 bit count", nb, 2 * np);
    endtask

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(!ds_data && !ds_strb && !data_drv_en && !strb_drv_en, "R1 reset outputs",
              {ds_data, ds_strb, data_drv_en, strb_drv_en}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check(!ds_data && !ds_strb && !data_drv_en && !strb_drv_en, "R1 after release",
              {ds_data, ds_strb, data_drv_en, strb_drv_en}, 0);

        for (int v = 0; v < 6; v++)
            run_pkt(VEC[v][12:11], int'(VEC[v][10:8]), VEC[v][7:0]);

        // R8: both reserved codes with the link asking to send
        for (int code = 2; code < 4; code++) begin
            @(negedge clk);
            speed_sel = 2'(code);
            tx_act = 1'b1;
            tx_pair = 2'b01;
            for (int c = 0; c < 6; c++) begin
                @(negedge clk);
                check(!pair_take, "R8 no tick when reserved", pair_take, 0);
                check(!ds_data && !ds_strb && !data_drv_en && !strb_drv_en, "R8 silent",
                      {ds_data, ds_strb, data_drv_en, strb_drv_en}, 0);
            end
        end

        // R8: reserved code forced in the middle of a packet
        @(negedge clk);
        speed_sel = 2'b00;
        tx_act = 1'b0;
        idle(3);
        while (!pair_take) @(negedge clk);
        tx_act = 1'b1;
        tx_pair = 2'b10;
        @(posedge clk);
        #1;
        check(data_drv_en && strb_drv_en, "R6 enables on first bit", {data_drv_en, strb_drv_en}, 3);
        @(negedge clk);
        speed_sel = 2'b11;
        @(posedge clk);
        #1;
        check(!ds_data && !ds_strb && !data_drv_en && !strb_drv_en, "R8 mid-packet stop",
              {ds_data, ds_strb, data_drv_en, strb_drv_en}, 0);
        @(negedge clk);
        speed_sel = 2'b00;
        tx_act = 1'b0;
        idle(4);
        check(!ds_data && !ds_strb && !data_drv_en, "R6 idle after recovery",
              {ds_data, ds_strb, data_drv_en}, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule